// File: doc/BRIEF.md
# Two-Rail Modified Sum Code Checker

This block watches a code word made of a data word and a received check word. From the data word it computes the check word again, using a modified count-of-ones code. The count of set data bits is reduced modulo a power of two. A correction bit then fills the top check position. That bit is the XOR of a chosen subset of the data bits. Each received check bit and its recomputed counterpart are turned into a two-rail pair. The pairs are then folded into a single pair by a network of two-rail compression cells.

A valid word gives a complementary output pair. Any mismatch gives an in-phase pair. Because of this, a stuck fault inside the comparison network also shows up as a bad output, and never as a silent match.

The compressed pair is registered once, so the verdict appears one clock after the inputs are sampled. Two layouts are used for the cells. A check width that is a power of two uses a balanced tree. Any other width uses a linear chain. With a single check bit the lone pair is used directly, and no cell is needed.

Top module: `sumcode_trc_checker`

## Requirements
- R1: With K = ceil(log2(DATA_W+1)) and M = 2^(K-1), the expected check word is (number of ones in the data word mod M) + c·M. Here c is the XOR of the data bits whose positions are set in CORR_MASK. The verdict is complementary exactly when chk_i equals this value.
- R2: verdict_o[0] is rail 0 and verdict_o[1] is rail 1. The values 2'b01 and 2'b10 mean a valid word, and 2'b00 and 2'b11 mean a fault. When exactly one received check bit is wrong, the verdict is that bit's received value on both rails.
- R3: For a valid word with K not a power of two (chain layout), verdict_o[0] = (XOR of chk_i bits) XOR ((K-1) mod 2), and verdict_o[1] is its inverse.
- R4: Any check word that differs from the expected one gives 2'b00 or 2'b11.
- R5: Flipping any single bit of a valid check word gives a non-complementary verdict.
- R6: Flipping an odd number of data bits while keeping the check word gives a non-complementary verdict.
- R7: With K = 1 (DATA_W = 1) the single two-rail pair is the verdict, and the formula of R3 still holds.
- R8: With K a power of two (tree layout), a valid word gives the same verdict value that R3 defines.
- R9: While rst_n is low at a rising edge, verdict_o becomes 2'b01 whatever the inputs are.
- R10: verdict_o is updated only at the rising clock edge. It shows the inputs present at that edge, and it holds its value between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | DATA_W | Monitored data word |
| chk_i | input | ceil(log2(DATA_W+1)) | Received check word |
| verdict_o | output | 2 | Registered two-rail verdict pair |

## Verification
Every verdict is due at the first rising edge after the inputs are applied. The bench therefore drives on the falling edge and samples one time unit after the next rising edge. One directed case also samples between the drive and that edge, to show the old verdict is still held. Three instances are run from the same stimulus: a chain layout (K=3), a tree layout (K=4) and the single-bit case. Each verdict is compared with the check word and the exact rail values computed by bench functions. The stimulus covers every data and check combination of the tree instance, plus random single check-bit flips and odd data-bit flips.

// File: rtl/sumcode_trc_pkg.sv
// Shared types and constants for the two-rail sum-code checker.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package sumcode_trc_pkg;

    // One two-rail signal: complementary rails mean "good".
    typedef struct packed {
        logic r1;
        logic r0;
    } rail_t;

    // Verdict value forced while reset is held.
    localparam logic [1:0] VERDICT_RESET = 2'b01;

endpackage

// File: rtl/sumcode_encoder.sv
// Modified sum-code encoder.
// Counts the ones in data_i and keeps them modulo M = 2^(CHK_W-1).
// The top check bit carries the XOR of the data bits picked by CORR_MASK.
// Assumes 1 <= DATA_W <= 64. With CHK_W == 1 the word is the correction bit alone.
module sumcode_encoder #(
    parameter int unsigned  DATA_W    = 5,
    parameter logic [63:0]  CORR_MASK = 64'h8,
    localparam int unsigned CHK_W     = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    logic [CHK_W-1:0] ones;
    logic             corr;

    // Population count of the data word.
    always_comb begin
        ones = '0;
        for (int i = 0; i < DATA_W; i++) begin
            ones = ones + CHK_W'(data_i[i]);
        end
    end

    // Correction bit: parity of the selected data positions.
    always_comb begin
        corr = ^(data_i & CORR_MASK[DATA_W-1:0]);
    end

    generate
        if (CHK_W == 1) begin : g_single
            assign chk_o = corr;
        end else begin : g_multi
            // Low bits hold the residue mod M, the top bit holds the correction weight.
            assign chk_o = {corr, ones[CHK_W-2:0]};
        end
    endgenerate

endmodule

// File: rtl/trc_cell.sv
// Two-rail compression cell.
// Gives a complementary output only when both input pairs are complementary.
// Pure combinational logic with no assumptions on the inputs.
module trc_cell
    import sumcode_trc_pkg::*;
(
    input  rail_t a_i,
    input  rail_t b_i,
    output rail_t z_o
);

    // Cross-coupled AND-OR pairs.
    always_comb begin
        z_o.r0 = (a_i.r0 & b_i.r0) | (a_i.r1 & b_i.r1);
        z_o.r1 = (a_i.r0 & b_i.r1) | (a_i.r1 & b_i.r0);
    end

endmodule

// File: rtl/trc_reducer.sv
// Folds N two-rail pairs into one pair with exactly N-1 cells.
// Uses a balanced heap tree when N is a power of two and a linear chain otherwise.
// With N == 1 the lone pair goes straight through.
module trc_reducer
    import sumcode_trc_pkg::*;
#(
    parameter int unsigned N = 3
) (
    input  rail_t [N-1:0] pairs_i,
    output rail_t         root_o
);

    generate
        if ((N & (N - 1)) == 0) begin : g_tree
            // Heap layout: node i has children 2i+1 and 2i+2; leaves sit at N-1 .. 2N-2.
            rail_t node [2*N-1];
            for (genvar j = 0; j < N; j++) begin : g_leaf
                assign node[N-1+j] = pairs_i[j];
            end
            for (genvar i = 0; i < N - 1; i++) begin : g_node
                trc_cell u_cell (
                    .a_i (node[2*i+1]),
                    .b_i (node[2*i+2]),
                    .z_o (node[i])
                );
            end
            assign root_o = node[0];
        end else begin : g_chain
            // Running fold: acc[i] merges acc[i-1] with pair i.
            rail_t acc [N];
            assign acc[0] = pairs_i[0];
            for (genvar i = 1; i < N; i++) begin : g_link
                trc_cell u_cell (
                    .a_i (acc[i-1]),
                    .b_i (pairs_i[i]),
                    .z_o (acc[i])
                );
            end
            assign root_o = acc[N-1];
        end
    endgenerate

endmodule

// File: rtl/sumcode_trc_checker.sv
// Two-rail modified sum-code checker, top level.
// Computes the check word again from data_i, pairs every received bit with its
// inverted recomputed twin, and compresses the pairs to one registered verdict.
// Assumes chk_i is produced by an independent predictor with the same parameters.
module sumcode_trc_checker
    import sumcode_trc_pkg::*;
#(
    parameter int unsigned  DATA_W    = 5,
    parameter logic [63:0]  CORR_MASK = 64'h8,
    localparam int unsigned CHK_W     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [1:0]        verdict_o
);

    logic [CHK_W-1:0]  regen_chk;
    rail_t [CHK_W-1:0] pairs;
    rail_t             root;

    sumcode_encoder #(
        .DATA_W    (DATA_W),
        .CORR_MASK (CORR_MASK)
    ) u_enc (
        .data_i (data_i),
        .chk_o  (regen_chk)
    );

    // Inverter bank: a received bit and its inverted twin form a two-rail pair.
    generate
        for (genvar j = 0; j < CHK_W; j++) begin : g_pair
            assign pairs[j].r0 = chk_i[j];
            assign pairs[j].r1 = ~regen_chk[j];
        end
    endgenerate

    trc_reducer #(
        .N (CHK_W)
    ) u_tree (
        .pairs_i (pairs),
        .root_o  (root)
    );

    // Register the compressed verdict once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_o <= VERDICT_RESET;
        end else begin
            verdict_o <= {root.r1, root.r0};
        end
    end

    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> verdict_o == VERDICT_RESET); // R9

    AST_MATCH_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_i == regen_chk) |=> (verdict_o[0] != verdict_o[1])); // R1

    AST_MISMATCH_INPHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_i != regen_chk) |=> (verdict_o[0] == verdict_o[1])); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(data_i) && $stable(chk_i)) |=> $stable(verdict_o)); // R10

    generate
        if (CHK_W > 1) begin : g_par_chk
            // An even modulus keeps the data parity in check bit 0, so odd flips are caught.
            AST_ODD_FLIP_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
                regen_chk[0] == ^data_i); // R6
        end
    endgenerate

endmodule

// File: tb/sumcode_trc_checker_bench.sv
// Bench: three instances (chain K=3, tree K=4, single K=1) driven together.
module sumcode_trc_checker_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] d5 = '0;
    logic [2:0] c5 = '0;
    logic [7:0] d8 = '0;
    logic [3:0] c8 = '0;
    logic [0:0] d1 = '0;
    logic [0:0] c1 = '0;
    logic [1:0] v5, v8, v1;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sumcode_trc_checker #(.DATA_W(5), .CORR_MASK(64'h08)) u_sumcode_trc_checker (
        .clk(clk), .rst_n(rst_n), .data_i(d5), .chk_i(c5), .verdict_o(v5));
    sumcode_trc_checker #(.DATA_W(8), .CORR_MASK(64'h5A)) u_tree (
        .clk(clk), .rst_n(rst_n), .data_i(d8), .chk_i(c8), .verdict_o(v8));
    sumcode_trc_checker #(.DATA_W(1), .CORR_MASK(64'h01)) u_single (
        .clk(clk), .rst_n(rst_n), .data_i(d1), .chk_i(c1), .verdict_o(v1));

    // Expected check word from R1.
    function automatic int unsigned exp_chk(int unsigned w, int unsigned mask, int unsigned d);
        int unsigned k = 0;
        int unsigned cnt = 0;
        int unsigned m;
        int unsigned a = 0;
        while ((1 << k) < w + 1) k++;
        for (int i = 0; i < w; i++) begin
            cnt += (d >> i) & 1;
            if (((mask >> i) & 1) != 0) a ^= (d >> i) & 1;
        end
        m = 1 << (k - 1);
        return (cnt % m) + a * m;
    endfunction

    // Exact verdict of a valid word (R3/R7/R8).
    function automatic logic [1:0] exp_valid(int unsigned k, int unsigned c);
        logic z0 = 1'b0;
        for (int i = 0; i < k; i++) z0 ^= 1'((c >> i) & 1);
        z0 ^= 1'((k - 1) & 1);
        return {~z0, z0};
    endfunction

    task automatic chk_eq(string req, logic [1:0] got, logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: verdict=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic chk_fault(string req, logic [1:0] got);
        checks++;
        if (got !== 2'b00 && got !== 2'b11) begin
            failures++;
            $display("FAIL %s: verdict=%b expected=00 or 11", req, got);
        end
    endtask

    // Judge all three instances against the inputs that were sampled.
    task automatic judge_all(string tag);
        if (c5 == 3'(exp_chk(5, 'h08, d5))) chk_eq({tag, " R1 R3 chain"}, v5, exp_valid(3, c5));
        else chk_fault({tag, " R1 R4 chain"}, v5);
        if (c8 == 4'(exp_chk(8, 'h5A, d8))) chk_eq({tag, " R1 R8 tree"}, v8, exp_valid(4, c8));
        else chk_fault({tag, " R1 R4 tree"}, v8);
        if (c1 == 1'(exp_chk(1, 'h01, d1))) chk_eq({tag, " R1 R7 single"}, v1, exp_valid(1, c1));
        else chk_fault({tag, " R1 R4 single"}, v1);
    endtask

    task automatic wait_result();
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));

        // R9: reset forces 01 even with faulty inputs.
        @(negedge clk);
        c5 = 3'd7; c8 = 4'd15; d8 = 8'h01;
        repeat (2) wait_result();
        chk_eq("R9 chain", v5, 2'b01);
        chk_eq("R9 tree", v8, 2'b01);
        chk_eq("R9 single", v1, 2'b01);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R3/R4/R7/R8: every data and check pairing of the tree instance.
        for (int d = 0; d < 256; d++) begin
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                d8 = 8'(d); c8 = 4'(c);
                d5 = 5'(d); c5 = 3'(c);
                d1 = 1'(d); c1 = 1'(c);
                wait_result();
                judge_all("sweep");
            end
        end

        // R10: verdict changes only at the edge.
        @(negedge clk);
        d5 = 5'd3; c5 = 3'(exp_chk(5, 'h08, 3)) ^ 3'b001;
        wait_result();
        chk_fault("R10 setup", v5);
        @(negedge clk);
        c5 = 3'(exp_chk(5, 'h08, 3));
        #1;
        chk_fault("R10 before edge", v5);
        wait_result();
        chk_eq("R10 after edge", v5, exp_valid(3, c5));
        #(CLK_PERIOD/2);
        chk_eq("R10 held", v5, exp_valid(3, c5));

        // R5/R2: single check-bit flips, exact in-phase value.
        for (int n = 0; n < 300; n++) begin
            int unsigned j5 = $urandom % 3;
            int unsigned j8 = $urandom % 4;
            @(negedge clk);
            d5 = 5'($urandom); d8 = 8'($urandom); d1 = 1'($urandom);
            c5 = 3'(exp_chk(5, 'h08, d5)) ^ 3'(1 << j5);
            c8 = 4'(exp_chk(8, 'h5A, d8)) ^ 4'(1 << j8);
            c1 = 1'(exp_chk(1, 'h01, d1)) ^ 1'b1;
            wait_result();
            chk_fault("R5 chain", v5);
            chk_eq("R2 chain", v5, {2{c5[j5]}});
            chk_fault("R5 tree", v8);
            chk_eq("R2 tree", v8, {2{c8[j8]}});
            chk_eq("R2 R5 single", v1, {2{c1[0]}});
        end

        // R6: odd number of data bits flipped, check word kept.
        for (int n = 0; n < 300; n++) begin
            logic [4:0] f5 = 5'($urandom);
            logic [7:0] f8 = 8'($urandom);
            logic [4:0] b5 = 5'($urandom);
            logic [7:0] b8 = 8'($urandom);
            logic [0:0] b1 = 1'($urandom);
            if (^f5 == 1'b0) f5[0] = ~f5[0];
            if (^f8 == 1'b0) f8[0] = ~f8[0];
            @(negedge clk);
            c5 = 3'(exp_chk(5, 'h08, b5)); d5 = b5 ^ f5;
            c8 = 4'(exp_chk(8, 'h5A, b8)); d8 = b8 ^ f8;
            c1 = 1'(exp_chk(1, 'h01, b1)); d1 = ~b1;
            wait_result();
            chk_fault("R6 chain", v5);
            chk_fault("R6 tree", v8);
            chk_fault("R6 single", v1);
        end

        // R3/R8: random valid words.
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            d5 = 5'($urandom); d8 = 8'($urandom); d1 = 1'($urandom);
            c5 = 3'(exp_chk(5, 'h08, d5));
            c8 = 4'(exp_chk(8, 'h5A, d8));
            c1 = 1'(exp_chk(1, 'h01, d1));
            wait_result();
            judge_all("valid");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule